// File: doc/BRIEF.md
# Segmented-Page Address Translator

This block turns a 20-bit logical address into a 20-bit physical address. The logical address is split into a segment number, a page number and a word offset. The physical address is a block number followed by the unchanged word offset. Two internal register tables hold the mapping, and software loads them through a write port. The segment table gives, for each segment, a page-table base and an access-rights code. The page table gives, for each index, a block number and a presence flag.

A request first checks the access rights of its segment. An eight-entry associative buffer, keyed on segment and page, is searched at the same time. A hit returns the block at once. On a miss the unit reads the segment base and adds it to the page number, then reads the page table. This walk costs two extra cycles. A walk that succeeds stores its result in the buffer, and entries are replaced oldest first. A reference to an absent page reports a page fault, and a forbidden access reports a protection fault. Each outcome is marked by a single-cycle done strobe.

Top module: `segpage_mmu`

## Requirements
- R1: Logical address bits [19:16] are the segment, [15:8] the page and [7:0] the word. The physical address is the 12-bit block in [19:8] followed by the word in [7:0]. With segment 6 at base 35 hex and page-table entry 37 hex holding block 019 (present), address 6027E gives 0197E.
- R2: The page-table index is the segment base plus the page number, taken modulo 256.
- R3: If no protection fault applies and the buffer holds the segment/page pair, `done` rises one cycle after the request is accepted, with `tlb_hit`=1 and the buffered block.
- R4: On a buffer miss with no protection fault, `done` rises three cycles after acceptance, with `tlb_hit`=0. `req_ready` is low during the two walk cycles.
- R5: A walk that reaches a present entry installs its segment/page/block in the buffer, so a repeat of the same address hits.
- R6: The buffer has 8 entries. When it is full, a new install replaces the entry that was installed earliest.
- R7: A walk that reaches an entry whose presence bit (table data bit 12) is 0 gives `page_fault`=1 and `paddr`=0. It installs nothing, so a repeat walks again.
- R8: Segment rights are table data bits [9:8]: 0 full access, 1 read-only, 2 execute-only, 3 system-only. Access codes are 0 read, 1 write, 2 fetch, and 3 behaves as read. A protection fault is raised when a write goes to a read-only segment, when a read or write goes to an execute-only segment, or when `req_sys`=0 reaches a system-only segment. The fault takes priority over buffer and walk, completes in one cycle, and gives `paddr`=0.
- R9: Any table write (`tbl_sel` 0 = segment entry with base in data [7:0], 1 = page entry with block in data [11:0]) empties the whole buffer by the next cycle.
- R10: After reset `done` is 0, `req_ready` is 1, the buffer is empty and all table entries are zero (base 0, full access, absent).
- R11: At most one of `tlb_hit`, `page_fault` and `prot_fault` is set, and each is set only while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, taken when `req_ready` is high |
| req_laddr | input | 20 | Logical address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_sys | input | 1 | 1 = system privilege, 0 = user |
| req_ready | output | 1 | Unit idle and able to take a request |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | 0 = segment table, 1 = page table |
| tbl_idx | input | 8 | Entry index (low 4 bits for the segment table) |
| tbl_data | input | 13 | Entry contents |
| done | output | 1 | One-cycle result strobe |
| paddr | output | 20 | Physical address, valid with `done` |
| tlb_hit | output | 1 | Result came from the buffer |
| page_fault | output | 1 | Referenced page is absent |
| prot_fault | output | 1 | Access rights violated |

## Verification
The bench builds the block with its default parameters: 4-bit segment, 8-bit page and word, 12-bit block, and eight buffer entries. With a 256-entry page table, base-plus-page wraparound is reachable. Limiting random pages to a dozen values per segment across all sixteen segments keeps the eight-entry buffer under steady eviction pressure, so hit and miss paths and oldest-first replacement all occur. Random table rewrites mixed in between translations exercise the flush, and all four rights codes are crossed with every access kind and both privilege levels.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } access_t;

    typedef enum logic [1:0] {
        RIGHTS_FULL  = 2'd0,
        RIGHTS_RDONLY = 2'd1,
        RIGHTS_EXEC  = 2'd2,
        RIGHTS_SYS   = 2'd3
    } rights_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEG  = 2'd1,
        ST_PAGE = 2'd2
    } walk_state_t;

    localparam logic TBL_SEGMENT = 1'b0;
    localparam logic TBL_PAGE    = 1'b1;

    function automatic logic rights_violation(rights_t r, access_t a, logic sys);
        logic bad;
        case (r)
            RIGHTS_RDONLY: bad = (a == ACC_WRITE);
            RIGHTS_EXEC:   bad = (a != ACC_FETCH);
            RIGHTS_SYS:    bad = !sys;
            default:       bad = 1'b0;
        endcase
        return bad;
    endfunction

endpackage

// File: rtl/mmu_tables.sv
module mmu_tables
    import mmu_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int PAGE_W = 8,
    parameter int BLK_W  = 12,
    parameter int TD_W   = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              sel,
    input  logic [PAGE_W-1:0] widx,
    input  logic [TD_W-1:0]   wdata,
    input  logic [SEG_W-1:0]  seg_ridx,
    output logic [PAGE_W-1:0] seg_base,
    output rights_t           seg_rights,
    input  logic [PAGE_W-1:0] pt_ridx,
    output logic [BLK_W-1:0]  pt_blk,
    output logic              pt_pres
);
    localparam int SEG_N = 1 << SEG_W;
    localparam int PT_N  = 1 << PAGE_W;

    logic [PAGE_W-1:0] base_q   [SEG_N];
    rights_t           rights_q [SEG_N];
    logic [BLK_W-1:0]  blk_q    [PT_N];
    logic [PT_N-1:0]   pres_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SEG_N; i++) begin
                base_q[i]   <= '0;
                rights_q[i] <= RIGHTS_FULL;
            end
            for (int i = 0; i < PT_N; i++) begin
                blk_q[i] <= '0;
            end
            pres_q <= '0;
        end else if (we) begin
            if (sel == TBL_SEGMENT) begin
                base_q[widx[SEG_W-1:0]]   <= wdata[PAGE_W-1:0];
                rights_q[widx[SEG_W-1:0]] <= rights_t'(wdata[PAGE_W+1:PAGE_W]);
            end else begin
                blk_q[widx]  <= wdata[BLK_W-1:0];
                pres_q[widx] <= wdata[BLK_W];
            end
        end
    end

    assign seg_base   = base_q[seg_ridx];
    assign seg_rights = rights_q[seg_ridx];
    assign pt_blk     = blk_q[pt_ridx];
    assign pt_pres    = pres_q[pt_ridx];

endmodule

// File: rtl/mmu_tlb.sv
module mmu_tlb #(
    parameter int N     = 8,
    parameter int KEY_W = 12,
    parameter int BLK_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [KEY_W-1:0] lk_key,
    output logic             lk_hit,
    output logic [BLK_W-1:0] lk_blk,
    input  logic             ins,
    input  logic [KEY_W-1:0] ins_key,
    input  logic [BLK_W-1:0] ins_blk,
    output logic [N-1:0]     vld_o
);
    localparam int PTR_W = $clog2(N);

    logic [N-1:0]     vld;
    logic [KEY_W-1:0] key_q [N];
    logic [BLK_W-1:0] blk_q [N];
    logic [PTR_W-1:0] ptr;
    logic [N-1:0]     match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = vld[g] && (key_q[g] == lk_key);
    end

    always_comb begin
        lk_blk = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) lk_blk = lk_blk | blk_q[i];
        end
    end

    assign lk_hit = |match;
    assign vld_o  = vld;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld <= '0;
            ptr <= '0;
        end else if (ins) begin
            vld[ptr]   <= 1'b1;
            key_q[ptr] <= ins_key;
            blk_q[ptr] <= ins_blk;
            ptr        <= (ptr == PTR_W'(N-1)) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/mmu_walk_ctrl.sv
module mmu_walk_ctrl
    import mmu_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int PAGE_W = 8,
    parameter int WORD_W = 8,
    parameter int BLK_W  = 12,
    localparam int LA_W  = SEG_W + PAGE_W + WORD_W,
    localparam int PA_W  = BLK_W + WORD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [LA_W-1:0]     req_laddr,
    input  access_t             req_acc,
    input  logic                req_sys,
    output logic                ready,
    input  logic                tlb_hit_i,
    input  logic [BLK_W-1:0]    tlb_blk_i,
    input  rights_t             seg_rights_i,
    input  logic [PAGE_W-1:0]   seg_base_i,
    input  logic [BLK_W-1:0]    pt_blk_i,
    input  logic                pt_pres_i,
    output logic [SEG_W-1:0]    seg_idx_o,
    output logic [PAGE_W-1:0]   pt_idx_o,
    output logic                install_o,
    output logic [SEG_W+PAGE_W-1:0] ins_key_o,
    output logic [BLK_W-1:0]    ins_blk_o,
    output logic                done,
    output logic [PA_W-1:0]     paddr,
    output logic                hit_o,
    output logic                page_fault,
    output logic                prot_fault
);
    walk_state_t       state;
    logic [LA_W-1:0]   lat_q;
    logic [PAGE_W-1:0] ptidx_q;
    logic              viol;

    assign ready     = (state == ST_IDLE);
    assign seg_idx_o = ready ? req_laddr[LA_W-1 -: SEG_W] : lat_q[LA_W-1 -: SEG_W];
    assign viol      = rights_violation(seg_rights_i, req_acc, req_sys);
    assign pt_idx_o  = ptidx_q;
    assign install_o = (state == ST_PAGE) && pt_pres_i;
    assign ins_key_o = lat_q[LA_W-1:WORD_W];
    assign ins_blk_o = pt_blk_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            lat_q      <= '0;
            ptidx_q    <= '0;
            done       <= 1'b0;
            paddr      <= '0;
            hit_o      <= 1'b0;
            page_fault <= 1'b0;
            prot_fault <= 1'b0;
        end else begin
            done       <= 1'b0;
            hit_o      <= 1'b0;
            page_fault <= 1'b0;
            prot_fault <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_q <= req_laddr;
                        if (viol) begin
                            done       <= 1'b1;
                            prot_fault <= 1'b1;
                            paddr      <= '0;
                        end else if (tlb_hit_i) begin
                            done  <= 1'b1;
                            hit_o <= 1'b1;
                            paddr <= {tlb_blk_i, req_laddr[WORD_W-1:0]};
                        end else begin
                            state <= ST_SEG;
                        end
                    end
                end
                ST_SEG: begin
                    ptidx_q <= seg_base_i + lat_q[WORD_W +: PAGE_W];
                    state   <= ST_PAGE;
                end
                ST_PAGE: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                    if (pt_pres_i) begin
                        paddr <= {pt_blk_i, lat_q[WORD_W-1:0]};
                    end else begin
                        paddr      <= '0;
                        page_fault <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/segpage_mmu.sv
module segpage_mmu
    import mmu_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int PAGE_W = 8,
    parameter int WORD_W = 8,
    parameter int BLK_W  = 12,
    parameter int TLB_N  = 8,
    localparam int TD_W  = (PAGE_W + 2 > BLK_W + 1) ? PAGE_W + 2 : BLK_W + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [SEG_W+PAGE_W+WORD_W-1:0] req_laddr,
    input  logic [1:0]                    req_acc,
    input  logic                          req_sys,
    output logic                          req_ready,
    input  logic                          tbl_we,
    input  logic                          tbl_sel,
    input  logic [PAGE_W-1:0]             tbl_idx,
    input  logic [TD_W-1:0]               tbl_data,
    output logic                          done,
    output logic [BLK_W+WORD_W-1:0]       paddr,
    output logic                          tlb_hit,
    output logic                          page_fault,
    output logic                          prot_fault
);
    localparam int KEY_W = SEG_W + PAGE_W;
    localparam int LA_W  = SEG_W + PAGE_W + WORD_W;

    logic [SEG_W-1:0]  seg_idx;
    logic [PAGE_W-1:0] seg_base;
    rights_t           seg_rights;
    logic [PAGE_W-1:0] pt_idx;
    logic [BLK_W-1:0]  pt_blk;
    logic              pt_pres;
    logic              lk_hit;
    logic [BLK_W-1:0]  lk_blk;
    logic              install;
    logic [KEY_W-1:0]  ins_key;
    logic [BLK_W-1:0]  ins_blk;
    logic [TLB_N-1:0]  tlb_vld;

    mmu_tables #(
        .SEG_W(SEG_W), .PAGE_W(PAGE_W), .BLK_W(BLK_W), .TD_W(TD_W)
    ) u_tables (
        .clk(clk), .rst(rst),
        .we(tbl_we), .sel(tbl_sel), .widx(tbl_idx), .wdata(tbl_data),
        .seg_ridx(seg_idx), .seg_base(seg_base), .seg_rights(seg_rights),
        .pt_ridx(pt_idx), .pt_blk(pt_blk), .pt_pres(pt_pres)
    );

    mmu_tlb #(
        .N(TLB_N), .KEY_W(KEY_W), .BLK_W(BLK_W)
    ) u_tlb (
        .clk(clk), .rst(rst), .flush(tbl_we),
        .lk_key(req_laddr[LA_W-1:WORD_W]), .lk_hit(lk_hit), .lk_blk(lk_blk),
        .ins(install), .ins_key(ins_key), .ins_blk(ins_blk),
        .vld_o(tlb_vld)
    );

    mmu_walk_ctrl #(
        .SEG_W(SEG_W), .PAGE_W(PAGE_W), .WORD_W(WORD_W), .BLK_W(BLK_W)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_laddr(req_laddr),
        .req_acc(access_t'(req_acc)), .req_sys(req_sys),
        .ready(req_ready),
        .tlb_hit_i(lk_hit), .tlb_blk_i(lk_blk),
        .seg_rights_i(seg_rights), .seg_base_i(seg_base),
        .pt_blk_i(pt_blk), .pt_pres_i(pt_pres),
        .seg_idx_o(seg_idx), .pt_idx_o(pt_idx),
        .install_o(install), .ins_key_o(ins_key), .ins_blk_o(ins_blk),
        .done(done), .paddr(paddr), .hit_o(tlb_hit),
        .page_fault(page_fault), .prot_fault(prot_fault)
    );

endmodule

// File: rtl/mmu_chk.sv
module mmu_chk #(
    parameter int TLB_N = 8,
    parameter int PA_W  = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             done,
    input logic [PA_W-1:0]  paddr,
    input logic             tlb_hit,
    input logic             page_fault,
    input logic             prot_fault,
    input logic             tbl_we,
    input logic [TLB_N-1:0] tlb_vld
);
    // R10
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && req_ready && tlb_vld == '0));

    // R3
    hit_latency_chk: assert property (@(posedge clk) disable iff (rst)
        tlb_hit |-> (done && $past(req_valid && req_ready)));

    // R4
    walk_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |=> (done && req_ready && !tlb_hit));

    // R7
    page_fault_chk: assert property (@(posedge clk) disable iff (rst)
        page_fault |-> (done && paddr == '0 && !$past(req_ready)));

    // R8
    prot_fault_chk: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> (done && paddr == '0 && $past(req_valid && req_ready)));

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_we |=> (tlb_vld == '0));

    // R11
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        (tlb_hit || page_fault || prot_fault) |->
            (done && $countones({tlb_hit, page_fault, prot_fault}) == 1));

endmodule

bind segpage_mmu mmu_chk #(.TLB_N(TLB_N), .PA_W(BLK_W + WORD_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .paddr(paddr), .tlb_hit(tlb_hit),
    .page_fault(page_fault), .prot_fault(prot_fault),
    .tbl_we(tbl_we), .tlb_vld(tlb_vld)
);

// File: tb/segpage_mmu_test.sv
module segpage_mmu_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_laddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_sys = 1'b0;
    logic        req_ready;
    logic        tbl_we = 1'b0;
    logic        tbl_sel = 1'b0;
    logic [7:0]  tbl_idx = '0;
    logic [12:0] tbl_data = '0;
    logic        done;
    logic [19:0] paddr;
    logic        tlb_hit;
    logic        page_fault;
    logic        prot_fault;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    segpage_mmu uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_laddr(req_laddr),
        .req_acc(req_acc), .req_sys(req_sys), .req_ready(req_ready),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
        .done(done), .paddr(paddr), .tlb_hit(tlb_hit),
        .page_fault(page_fault), .prot_fault(prot_fault)
    );

    // reference state
    logic [7:0]  m_base  [16];
    logic [1:0]  m_right [16];
    logic [11:0] m_blk   [256];
    logic        m_pres  [256];
    logic [11:0] t_key   [8];
    logic [11:0] t_blk   [8];
    logic        t_v     [8];
    int          t_ptr;

    function automatic logic rights_bad(logic [1:0] r, logic [1:0] a, logic s);
        if (r == 2'd1) return a == 2'd1;
        if (r == 2'd2) return a != 2'd2;
        if (r == 2'd3) return !s;
        return 1'b0;
    endfunction

    task automatic model_flush();
        for (int i = 0; i < 8; i++) t_v[i] = 1'b0;
        t_ptr = 0;
    endtask

    task automatic check(input string tag, input logic ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic load(input logic sel, input logic [7:0] idx, input logic [12:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = sel; tbl_idx = idx; tbl_data = d;
        @(negedge clk);
        tbl_we = 1'b0;
        if (sel == 1'b0) begin
            m_base[idx[3:0]]  = d[7:0];
            m_right[idx[3:0]] = d[9:8];
        end else begin
            m_blk[idx]  = d[11:0];
            m_pres[idx] = d[12];
        end
        model_flush();
        // R9: buffer emptied; verified by following translations missing
    endtask

    task automatic xlate(input logic [19:0] a, input logic [1:0] acc, input logic sys,
                         input string tag);
        logic        e_hit, e_pf, e_prf;
        logic [19:0] e_pa;
        int          e_lat, lat, slot;
        logic [7:0]  idx;
        e_hit = 0; e_pf = 0; e_prf = 0; e_pa = '0; slot = -1;
        if (rights_bad(m_right[a[19:16]], acc, sys)) begin
            e_prf = 1; e_lat = 1;
        end else begin
            for (int i = 0; i < 8; i++)
                if (t_v[i] && t_key[i] == a[19:8]) slot = i;
            if (slot >= 0) begin
                e_hit = 1; e_lat = 1; e_pa = {t_blk[slot], a[7:0]};
            end else begin
                e_lat = 3;
                idx = m_base[a[19:16]] + a[15:8];
                if (m_pres[idx]) begin
                    e_pa = {m_blk[idx], a[7:0]};
                    t_key[t_ptr] = a[19:8]; t_blk[t_ptr] = m_blk[idx];
                    t_v[t_ptr] = 1'b1; t_ptr = (t_ptr + 1) % 8;
                end else begin
                    e_pf = 1;
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_laddr = a; req_acc = acc; req_sys = sys;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(tag, lat == e_lat, "latency", 64'(lat), 64'(e_lat));
        check(tag, {tlb_hit, page_fault, prot_fault} == {e_hit, e_pf, e_prf},
              "hit/pf/prot", {61'd0, tlb_hit, page_fault, prot_fault},
              {61'd0, e_hit, e_pf, e_prf});
        check(tag, paddr == e_pa, "paddr", 64'(paddr), 64'(e_pa));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20577);
        for (int i = 0; i < 16; i++) begin m_base[i] = '0; m_right[i] = '0; end
        for (int i = 0; i < 256; i++) begin m_blk[i] = '0; m_pres[i] = 1'b0; end
        model_flush();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10", done == 1'b0 && req_ready == 1'b1, "done/ready",
              {62'd0, done, req_ready}, 64'd1);
        xlate(20'h3_0512, 2'd0, 1'b0, "R10 all-absent tables");

        // R1 worked example, R2 base + page
        load(1'b0, 8'd6, {3'b000, 2'd0, 8'h35});
        load(1'b1, 8'h37, {1'b1, 12'h019});
        xlate(20'h6_027E, 2'd0, 1'b0, "R1 R2 example");
        xlate(20'h6_027E, 2'd0, 1'b0, "R3 R5 repeat hits");
        // R2 wraparound: base F0 + page 20 -> index 10
        load(1'b0, 8'd2, {3'b000, 2'd0, 8'hF0});
        load(1'b1, 8'h10, {1'b1, 12'hABC});
        xlate(20'h2_2044, 2'd2, 1'b0, "R2 wrap");

        // R7 absent page, no install
        xlate(20'h6_0300, 2'd0, 1'b0, "R7 absent");
        xlate(20'h6_0300, 2'd0, 1'b0, "R7 no install");

        // R6 FIFO: segment 1 base 0, pages 0..8
        load(1'b0, 8'd1, {3'b000, 2'd0, 8'h00});
        for (int p = 0; p < 9; p++) load(1'b1, 8'(p), {1'b1, 12'(12'h100 + p)});
        for (int p = 0; p < 9; p++) xlate({4'd1, 8'(p), 8'h11}, 2'd1, 1'b0, "R6 fill");
        xlate({4'd1, 8'd1, 8'h22}, 2'd0, 1'b0, "R6 second oldest kept");
        xlate({4'd1, 8'd0, 8'h33}, 2'd0, 1'b0, "R6 oldest evicted");

        // R9 rewrite flushes
        xlate({4'd1, 8'd3, 8'h01}, 2'd0, 1'b0, "R9 before");
        load(1'b1, 8'd3, {1'b1, 12'h777});
        xlate({4'd1, 8'd3, 8'h01}, 2'd0, 1'b0, "R9 after rewrite");

        // R8 all rights x access x privilege
        for (int r = 0; r < 4; r++) begin
            load(1'b0, 8'd1, {3'b000, 2'(r), 8'h00});
            for (int a = 0; a < 4; a++)
                for (int s = 0; s < 2; s++)
                    xlate({4'd1, 8'd4, 8'h5A}, 2'(a), 1'(s), "R8 rights");
        end

        // random tables and traffic (R3 R4 R5 R6 R11)
        for (int i = 0; i < 16; i++)
            load(1'b0, 8'(i), {3'b000, ($urandom % 4 == 0) ? 2'($urandom) : 2'd0,
                               8'($urandom)});
        for (int i = 0; i < 256; i++)
            load(1'b1, 8'(i), {($urandom % 8 != 0), 12'($urandom)});
        for (int k = 0; k < 1500; k++) begin
            if ($urandom % 40 == 0)
                load($urandom % 2 == 0, 8'($urandom), 13'($urandom));
            xlate({4'($urandom), 8'($urandom % 12), 8'($urandom)},
                  2'($urandom), 1'($urandom), "R4 R11 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule